// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the effective memory address for a load or store and, when the access asks for it, the updated value of the base register. It takes a base value (a general register, the program counter for PC-relative access, or the stack pointer: the unit does not care which), an offset that is either a zero-extended immediate or a second register value shifted left by a scale amount, an add/subtract direction, an indexing mode and a write-back request.

Three indexing modes are supported. In offset-only mode the address is base plus or minus the offset and the base is untouched. In pre-index mode the same sum is both the address and the new base. In post-index mode the unmodified base goes to memory and the sum becomes the new base. All results are registered and appear one cycle after a valid input, marked by an output valid flag. A small two-state machine tracks output validity: EMPTY (no result held) and LOADED (a result is on the outputs). Transitions: EMPTY to LOADED on an accepted input, LOADED to LOADED on a back-to-back input, LOADED to EMPTY on a cycle with no input, EMPTY to EMPTY when idle; reset forces EMPTY.

Top module: `agu_top`

## Requirements
- R1: With `idx_mode` = 0 (offset only) the next `mem_addr` is base combined with the offset, `new_base` equals the unchanged base and `wb_stb` stays low; code 3 behaves exactly like code 0.
- R2: With `idx_mode` = 1 (pre-index) and `wb_req` = 1, `mem_addr` and `new_base` both equal base combined with the offset and `wb_stb` is high.
- R3: With `idx_mode` = 2 (post-index) `mem_addr` equals the unmodified base; with `wb_req` = 1 `new_base` equals base combined with the offset and `wb_stb` is high.
- R4: When `use_reg` = 1 the offset is `reg_ofs`; when `use_reg` = 0 it is `imm_ofs` zero-extended to 32 bits and `shamt` has no effect.
- R5: A register offset is shifted left by `shamt` (0 to 31) before use; bits shifted past bit 31 are lost, so `shamt` = 2 multiplies it by 4.
- R6: `add_sel` = 1 adds the offset to the base, `add_sel` = 0 subtracts it; all arithmetic wraps modulo 2^32.
- R7: Outputs update on the clock edge after `in_valid` is high; `out_valid` is high exactly in the cycle after an accepted input and low otherwise, while data outputs hold their last values.
- R8: `wb_stb` is high only for pre- or post-index with `wb_req` = 1; for pre- or post-index with `wb_req` = 0, `new_base` equals the unchanged base.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `wb_stb`, `mem_addr` and `new_base` are cleared to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| base_val | input | 32 | Base register value |
| use_reg | input | 1 | 1 selects register offset, 0 immediate |
| imm_ofs | input | 12 | Immediate offset, zero-extended |
| reg_ofs | input | 32 | Register offset value |
| shamt | input | 5 | Left-shift amount for register offset |
| add_sel | input | 1 | 1 add offset, 0 subtract offset |
| idx_mode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 as 0 |
| wb_req | input | 1 | Base write-back requested |
| out_valid | output | 1 | Registered results valid |
| mem_addr | output | 32 | Effective memory address |
| new_base | output | 32 | Base value to write back |
| wb_stb | output | 1 | Write-back strobe |

## Verification
Random operands cover all four mode codes, both offset sources, both directions and every shift amount, so a swap between address and new base, or between pre- and post-index, shows as a mismatch on one of the two outputs. Directed cases target wrap-around at 2^32 in both directions, a shift of 31 that drops high bits, an immediate paired with a non-zero shift (which must be ignored), and write-back requests in offset-only mode and withheld in indexed modes, which separates the strobe logic from the arithmetic. Idle gaps between transactions show whether valid falls and data holds.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        IDX_OFS  = 2'd0,
        IDX_PRE  = 2'd1,
        IDX_POST = 2'd2,
        IDX_RSV  = 2'd3
    } idx_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHIFT_W = 5
) (
    input  logic               use_reg,
    input  logic [IMM_W-1:0]   imm_ofs,
    input  logic [ADDR_W-1:0]  reg_ofs,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [ADDR_W-1:0]  ofs
);
    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] reg_scaled;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm_ofs};
        end else begin : g_nopad
            assign imm_ext = imm_ofs[ADDR_W-1:0];
        end
    endgenerate

    // Scale only the register form; the immediate is used as given.
    assign reg_scaled = reg_ofs << shamt;
    assign ofs        = use_reg ? reg_scaled : imm_ext;
endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs,
    input  logic              add_sel,
    output logic [ADDR_W-1:0] sum
);
    // Modulo 2^ADDR_W by width truncation.
    always_comb begin
        if (add_sel) sum = base + ofs;
        else         sum = base - ofs;
    end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               use_reg,
    input  logic [IMM_W-1:0]   imm_ofs,
    input  logic [ADDR_W-1:0]  reg_ofs,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               add_sel,
    input  logic [1:0]         idx_mode,
    input  logic               wb_req,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  new_base,
    output logic               wb_stb
);
    import agu_pkg::*;

    logic [ADDR_W-1:0] ofs;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] nb_d;
    logic              stb_d;
    idx_mode_e         mode;
    out_state_e        state_q, state_d;

    assign mode = idx_mode_e'(idx_mode);

    agu_offset #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT_W(SHIFT_W)) i_ofs (
        .use_reg (use_reg),
        .imm_ofs (imm_ofs),
        .reg_ofs (reg_ofs),
        .shamt   (shamt),
        .ofs     (ofs)
    );

    agu_adder #(.ADDR_W(ADDR_W)) i_add (
        .base    (base_val),
        .ofs     (ofs),
        .add_sel (add_sel),
        .sum     (sum)
    );

    // Mode decode: which value goes to memory, which back to the base.
    always_comb begin
        addr_d = sum;
        nb_d   = base_val;
        stb_d  = 1'b0;
        unique case (mode)
            IDX_PRE: begin
                addr_d = sum;
                stb_d  = wb_req;
                nb_d   = wb_req ? sum : base_val;
            end
            IDX_POST: begin
                addr_d = base_val;
                stb_d  = wb_req;
                nb_d   = wb_req ? sum : base_val;
            end
            IDX_OFS, IDX_RSV: begin
                addr_d = sum;
            end
        endcase
    end

    // Next-state logic of the output validity machine.
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output register: data captured only on an accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            new_base <= '0;
            wb_stb   <= 1'b0;
        end else begin
            wb_stb <= in_valid & stb_d;
            if (in_valid) begin
                mem_addr <= addr_d;
                new_base <= nb_d;
            end
        end
    end

    assign out_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] base_val,
    input logic [1:0]        idx_mode,
    input logic              wb_req,
    input logic              out_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] new_base,
    input logic              wb_stb
);
    // R9
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !wb_stb));

    // R7
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_stb));

    // R7: data holds through idle cycles
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid) |=> ($stable(mem_addr) && $stable(new_base)));

    // R1
    assert_offset_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (idx_mode == 2'd0 || idx_mode == 2'd3))
        |=> (!wb_stb && new_base == $past(base_val)));

    // R2
    assert_pre_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idx_mode == 2'd1 && wb_req) |=> (wb_stb && new_base == mem_addr));

    // R3
    assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idx_mode == 2'd2) |=> (mem_addr == $past(base_val)));

    // R8
    assert_no_req_no_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wb_req) |=> (!wb_stb && new_base == $past(base_val)));

    assert_stb_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> out_valid);
endmodule

bind agu_top agu_checker #(.ADDR_W(ADDR_W)) i_agu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .base_val  (base_val),
    .idx_mode  (idx_mode),
    .wb_req    (wb_req),
    .out_valid (out_valid),
    .mem_addr  (mem_addr),
    .new_base  (new_base),
    .wb_stb    (wb_stb)
);

// File: tb/test_agu_top.sv
`timescale 1ns/1ps
module test_agu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] base_val;
    logic        use_reg;
    logic [11:0] imm_ofs;
    logic [31:0] reg_ofs;
    logic [4:0]  shamt;
    logic        add_sel;
    logic [1:0]  idx_mode;
    logic        wb_req;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [31:0] new_base;
    logic        wb_stb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    agu_top i_agu_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
        .use_reg(use_reg), .imm_ofs(imm_ofs), .reg_ofs(reg_ofs), .shamt(shamt),
        .add_sel(add_sel), .idx_mode(idx_mode), .wb_req(wb_req),
        .out_valid(out_valid), .mem_addr(mem_addr), .new_base(new_base), .wb_stb(wb_stb)
    );

    function automatic logic [31:0] exp_ofs(logic ur, logic [11:0] im, logic [31:0] ro, logic [4:0] sh);
        logic [31:0] r;
        if (ur) begin
            r = ro;
            for (int i = 0; i < 32; i++) if (i < int'(sh)) r = {r[30:0], 1'b0};
        end else r = {20'd0, im};
        return r;
    endfunction

    function automatic logic [31:0] exp_sum(logic [31:0] b, logic [31:0] o, logic a);
        logic [32:0] t;
        if (a) t = {1'b0, b} + {1'b0, o};
        else   t = {1'b0, b} + {1'b0, ~o} + 33'd1;
        return t[31:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one transaction at a falling edge, check at the next falling edge.
    task automatic txn(logic [31:0] b, logic ur, logic [11:0] im, logic [31:0] ro,
                       logic [4:0] sh, logic a, logic [1:0] m, logic wr);
        logic [31:0] s, ea, enb;
        logic        es;
        string       tag;
        in_valid = 1'b1; base_val = b; use_reg = ur; imm_ofs = im; reg_ofs = ro;
        shamt = sh; add_sel = a; idx_mode = m; wb_req = wr;
        s = exp_sum(b, exp_ofs(ur, im, ro, sh), a);
        case (m)
            2'd1:    begin ea = s; es = wr; enb = wr ? s : b; tag = "R2"; end
            2'd2:    begin ea = b; es = wr; enb = wr ? s : b; tag = "R3"; end
            default: begin ea = s; es = 1'b0; enb = b; tag = "R1"; end
        endcase
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, "/R4/R5/R6 addr"}, mem_addr, ea);
        check({tag, "/R8 new_base"}, new_base, enb);
        check({tag, "/R8 wb_stb"}, {31'd0, wb_stb}, {31'd0, es});
        check("R7 out_valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_a, hold_b;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b1; base_val = 32'hDEAD_BEEF; use_reg = 1'b0;
        imm_ofs = 12'h10; reg_ofs = '0; shamt = '0; add_sel = 1'b1; idx_mode = 2'd1; wb_req = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset clears everything even with input presented
        check("R9 out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 wb_stb", {31'd0, wb_stb}, 32'd0);
        check("R9 mem_addr", mem_addr, 32'd0);
        check("R9 new_base", new_base, 32'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);

        // Directed corners
        txn(32'h1000, 1'b0, 12'h004, 32'h0, 5'd0, 1'b1, 2'd0, 1'b1); // R1 offset with wb_req ignored
        txn(32'h1000, 1'b0, 12'h004, 32'h0, 5'd0, 1'b1, 2'd1, 1'b1); // R2
        txn(32'h1000, 1'b0, 12'h004, 32'h0, 5'd0, 1'b1, 2'd2, 1'b1); // R3
        txn(32'h2000, 1'b1, 12'h000, 32'h3, 5'd2, 1'b1, 2'd0, 1'b0); // R5 x4
        txn(32'hFFFF_FFFF, 1'b1, 12'h0, 32'h1, 5'd0, 1'b1, 2'd1, 1'b1); // R6 wrap up
        txn(32'h0000_0002, 1'b0, 12'h005, 32'h0, 5'd0, 1'b0, 2'd1, 1'b1); // R6 wrap down
        txn(32'h0, 1'b1, 12'h0, 32'hFFFF_FFFF, 5'd31, 1'b1, 2'd0, 1'b0); // R5 shift 31
        txn(32'h100, 1'b0, 12'hFFF, 32'h55, 5'd7, 1'b1, 2'd0, 1'b0);   // R4 shamt ignored
        txn(32'h300, 1'b0, 12'h010, 32'h0, 5'd0, 1'b0, 2'd3, 1'b1);    // R1 code 3
        txn(32'h400, 1'b1, 12'h0, 32'h8, 5'd1, 1'b1, 2'd1, 1'b0);      // R8 pre no req
        txn(32'h500, 1'b1, 12'h0, 32'h8, 5'd1, 1'b0, 2'd2, 1'b0);      // R8 post no req

        // R7: idle cycle drops valid, data holds
        hold_a = mem_addr; hold_b = new_base;
        @(negedge clk);
        check("R7 valid low", {31'd0, out_valid}, 32'd0);
        check("R7 stb low", {31'd0, wb_stb}, 32'd0);
        check("R7 addr hold", mem_addr, hold_a);
        check("R7 base hold", new_base, hold_b);

        // Random traffic with occasional gaps
        for (int n = 0; n < 400; n++) begin
            txn($urandom, 1'($urandom), 12'($urandom), $urandom, 5'($urandom),
                1'($urandom), 2'($urandom), 1'($urandom));
            if (($urandom % 4) == 0) begin
                @(negedge clk);
                check("R7 gap valid", {31'd0, out_valid}, 32'd0);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule